// File: doc/BRIEF.md
# Configurable Sinc Decimation Filter

This block turns a one-bit delta-sigma bitstream into multi-bit samples. Every bit that arrives with its valid strobe is weighted +1 (for a 1) or -1 (for a 0) and passed through a chain of wrap-around integrators. A decimation counter picks out one of every N valid bits, and at that bit a chain of differentiators forms the filtered sample. The sample is then placed in a 32-bit output word, and a strobe that lasts one cycle marks it as new.

The filter shape is chosen at run time. Three settings are plain sinc filters of order one, two or three. The fourth is a fast variant: a second-order filter with one extra integrator in front of it and no matching differentiator. The decimation ratio is an 8-bit field plus one. The sample can be delivered as a full 32-bit two's-complement value. It can also be delivered as a 16-bit window, taken from the full value at a programmable shift and placed in the upper half of the word.

The filter runs only while both its channel enable and the global enable are high. An external sync pulse, if allowed, restarts the filter. This lets sampling be aligned to an outside event such as a PWM period. After any start or restart, the first outputs of a higher-order filter are not yet settled, so they are dropped without a strobe.

Top module: `sinc_decim_filter`

## Requirements
- R1: After reset, `data_out` is 0 and `data_new` is 0.
- R2: With the filter running, `data_new` is high for exactly one cycle after every (`osr_field`+1)-th valid bit, counted from the last start or restart. Cycles with `bit_vld` low do not advance the count. `osr_field` = 255 gives a ratio of 256.
- R3: The filter produces no strobe and leaves `data_out` unchanged unless `chan_en` and `glob_en` are both 1. Dropping either enable clears all filter state.
- R4: A valid 1 counts as +1 and a valid 0 as -1. With `flt_kind` = 2'b01 (first order), each sample is the sum of the weights in its block.
- R5: `flt_kind` = 2'b10 selects second order and 2'b11 selects third order. For a constant input and ratio R, the settled output is +R^order for all ones and -R^order for all zeros.
- R6: `flt_kind` = 2'b00 selects the fast variant: three integrators followed by two differentiators. With all ones and ratio 4, the outputs it delivers are 80, 144 and 208.
- R7: After a start or restart, the first (order-1) decimated samples are discarded without a strobe. The count is 0 for first order, 1 for second order and for the fast variant, and 2 for third order.
- R8: When `sync_en` = 1, a high `sync_pulse` clears all filter state. A valid bit in the same cycle is dropped, and no strobe comes from that cycle. When `sync_en` = 0, the pulse has no effect.
- R9: With `fmt32` = 1, `data_out[31:0]` holds the full 32-bit two's-complement result.
- R10: With `fmt32` = 0, `data_out[31:16]` holds bits `win_shift`+15 down to `win_shift` of the result, sign-extended when the window passes bit 31, and `data_out[15:0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Valid strobe for `bit_in` |
| bit_in | input | 1 | Modulator data bit |
| flt_kind | input | 2 | 00 fast, 01 first, 10 second, 11 third order |
| osr_field | input | 8 | Decimation ratio minus one |
| chan_en | input | 1 | Channel enable |
| glob_en | input | 1 | Global enable, ANDed with `chan_en` |
| sync_en | input | 1 | Allows `sync_pulse` to restart the filter |
| sync_pulse | input | 1 | External restart pulse |
| fmt32 | input | 1 | 1: 32-bit result, 0: shifted 16-bit window |
| win_shift | input | 5 | Window shift for the 16-bit format |
| data_out | output | 32 | Filtered sample |
| data_new | output | 1 | One-cycle new-sample strobe |

## Verification
A restart from the sync pulse can fall in the same cycle as the valid bit that would close a decimation block. The bench provokes this by sending three bits of a ratio-4 block and raising the pulse together with the fourth bit. The check is that no strobe appears from that cycle, and that the next block of four zeros, counted afresh, yields exactly -4. That value is only possible if the pulse cleared the integrators and dropped the coincident bit. A separate case confirms that the same pulse with `sync_en` low leaves the running block intact.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  localparam int ACC_W = 32;
  localparam int OSR_W = 8;
  localparam int SH_W  = 5;
  localparam int NSTG  = 3;

  typedef enum logic [1:0] {
    FLT_FAST = 2'b00,
    FLT_ORD1 = 2'b01,
    FLT_ORD2 = 2'b10,
    FLT_ORD3 = 2'b11
  } flt_kind_e;

  // index of the last integrator used (0-based)
  function automatic logic [1:0] integ_last(flt_kind_e k);
    case (k)
      FLT_ORD1: return 2'd0;
      FLT_ORD2: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction

  // index of the last differentiator used, equal to order minus one
  function automatic logic [1:0] diff_last(flt_kind_e k);
    case (k)
      FLT_ORD1: return 2'd0;
      FLT_ORD3: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/sdf_integ.sv
module sdf_integ #(
  parameter int W     = 32,
  parameter int NSTG  = 3,
  localparam int SEL_W = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             bit_in,
  input  logic [SEL_W-1:0] tap_sel,
  output logic [W-1:0]     tap_nxt
);

  logic [NSTG-1:0][W-1:0] taps;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    logic [W-1:0] acc_q, acc_d, addend, sum;

    if (g == 0) begin : g_head
      assign addend = {{(W-1){~bit_in}}, 1'b1};
    end else begin : g_tail
      assign addend = g_stg[g-1].sum;
    end

    assign sum     = acc_q + addend;
    assign taps[g] = sum;

    always_comb begin
      acc_d = acc_q;
      if (clr)       acc_d = '0;
      else if (step) acc_d = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end
  end

  assign tap_nxt = taps[tap_sel];

endmodule

// File: rtl/sdf_decim.sv
module sdf_decim #(
  parameter int OSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [OSR_W-1:0] osr,
  output logic             dec
);

  logic [OSR_W-1:0] cnt_q, cnt_d;

  assign dec = step && (cnt_q == osr);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (dec)  cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sdf_comb.sv
module sdf_comb #(
  parameter int W     = 32,
  parameter int NSTG  = 3,
  localparam int SEL_W = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             dec,
  input  logic [SEL_W-1:0] out_sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     result,
  output logic             keep
);

  logic [NSTG-1:0][W-1:0] taps;
  logic [SEL_W-1:0]       skip_q, skip_d;

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    logic [W-1:0] z_q, z_d, src, diff;

    if (g == 0) begin : g_head
      assign src = din;
    end else begin : g_tail
      assign src = g_stg[g-1].diff;
    end

    assign diff    = src - z_q;
    assign taps[g] = diff;

    always_comb begin
      z_d = z_q;
      if (clr)      z_d = '0;
      else if (dec) z_d = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) z_q <= '0;
      else        z_q <= z_d;
    end
  end

  assign result = taps[out_sel];
  assign keep   = dec && (skip_q >= out_sel);

  always_comb begin
    skip_d = skip_q;
    if (clr)                          skip_d = '0;
    else if (dec && skip_q < out_sel) skip_d = skip_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_q <= '0;
    else        skip_q <= skip_d;
  end

endmodule

// File: rtl/sinc_decim_filter.sv
module sinc_decim_filter
  import sdf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_vld,
  input  logic        bit_in,
  input  logic [1:0]  flt_kind,
  input  logic [7:0]  osr_field,
  input  logic        chan_en,
  input  logic        glob_en,
  input  logic        sync_en,
  input  logic        sync_pulse,
  input  logic        fmt32,
  input  logic [4:0]  win_shift,
  output logic [31:0] data_out,
  output logic        data_new
);

  localparam int SEL_W = $clog2(NSTG);

  flt_kind_e        kind;
  logic             run, clr, step, dec, keep;
  logic [SEL_W-1:0] isel, dsel;
  logic [ACC_W-1:0] integ_tap, result, shifted;
  logic [31:0]      word_d, out_d;
  logic             new_d;

  assign kind = flt_kind_e'(flt_kind);
  assign isel = SEL_W'(integ_last(kind));
  assign dsel = SEL_W'(diff_last(kind));
  assign run  = chan_en && glob_en;
  assign clr  = !run || (sync_en && sync_pulse);
  assign step = bit_vld && !clr;

  sdf_integ #(.W(ACC_W), .NSTG(NSTG)) u_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .bit_in(bit_in), .tap_sel(isel), .tap_nxt(integ_tap)
  );

  sdf_decim #(.OSR_W(OSR_W)) u_decim (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .osr(osr_field), .dec(dec)
  );

  sdf_comb #(.W(ACC_W), .NSTG(NSTG)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .dec(dec),
    .out_sel(dsel), .din(integ_tap), .result(result), .keep(keep)
  );

  // output formatting: full word or shifted 16-bit window in the upper half
  always_comb begin
    shifted = ACC_W'($signed(result) >>> win_shift);
    word_d  = fmt32 ? result[31:0] : {shifted[15:0], 16'h0000};
    out_d   = keep ? word_d : data_out;
    new_d   = keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      data_new <= 1'b0;
    end else begin
      data_out <= out_d;
      data_new <= new_d;
    end
  end

endmodule

// File: rtl/sdf_chk.sv
module sdf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_vld,
  input logic        chan_en,
  input logic        glob_en,
  input logic        sync_en,
  input logic        sync_pulse,
  input logic        fmt32,
  input logic [31:0] data_out,
  input logic        data_new
);

  // a strobe only follows a cycle that carried a valid bit
  assert_strobe_needs_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_new |-> $past(bit_vld));

  // the output word only moves together with the strobe
  assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> data_new);

  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(chan_en && glob_en) |=> !data_new);

  assert_sync_drops_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && sync_pulse) |=> !data_new);

  assert_low_half_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_new && !$past(fmt32)) |-> (data_out[15:0] == 16'h0000));

endmodule

bind sinc_decim_filter sdf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .chan_en(chan_en),
  .glob_en(glob_en), .sync_en(sync_en), .sync_pulse(sync_pulse),
  .fmt32(fmt32), .data_out(data_out), .data_new(data_new)
);

// File: tb/sinc_decim_filter_tb.sv
module sinc_decim_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_vld = 1'b0, bit_in = 1'b0;
  logic [1:0]  flt_kind = 2'b01;
  logic [7:0]  osr_field = 8'd3;
  logic        chan_en = 1'b0, glob_en = 1'b0, sync_en = 1'b0, sync_pulse = 1'b0;
  logic        fmt32 = 1'b1;
  logic [4:0]  win_shift = 5'd0;
  logic [31:0] data_out;
  logic        data_new;

  int checks = 0, failures = 0, n_strobe = 0;
  logic        got_new;
  logic [31:0] got_val;

  always #5 clk = ~clk;

  sinc_decim_filter u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .flt_kind(flt_kind), .osr_field(osr_field), .chan_en(chan_en),
    .glob_en(glob_en), .sync_en(sync_en), .sync_pulse(sync_pulse),
    .fmt32(fmt32), .win_shift(win_shift), .data_out(data_out), .data_new(data_new)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic syn);
    @(negedge clk);
    bit_vld = 1'b1; bit_in = b; sync_pulse = syn;
    @(posedge clk); #1;
    got_new = data_new; got_val = data_out;
    if (data_new) n_strobe++;
    bit_vld = 1'b0; sync_pulse = 1'b0;
  endtask

  task automatic feed(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b, 1'b0);
  endtask

  task automatic setup(input logic [1:0] k, input logic [7:0] osr, input logic f32,
                       input logic [4:0] sh, input logic sen);
    @(negedge clk);
    chan_en = 1'b0;
    @(negedge clk);
    flt_kind = k; osr_field = osr; fmt32 = f32; win_shift = sh; sync_en = sen;
    glob_en = 1'b1; chan_en = 1'b1;
    n_strobe = 0;
  endtask

  task automatic t_reset;
    check("R1 data_out after reset", data_out, 32'h0);
    check("R1 data_new after reset", {31'b0, data_new}, 32'h0);
  endtask

  task automatic t_first_order;
    setup(2'b01, 8'd3, 1'b1, 5'd0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      send_bit(1'b1, 1'b0);
      check("R2 strobe only on 4th valid bit", {31'b0, got_new}, (i == 3) ? 32'h1 : 32'h0);
      repeat (2) @(posedge clk);
    end
    check("R4 all-ones block sum", got_val, 32'd4);
    @(negedge clk);
    check("R2 strobe lasts one cycle", {31'b0, data_new}, 32'h0);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    check("R4 mixed block sum", got_val, 32'd2);
  endtask

  task automatic t_second_third;
    setup(2'b10, 8'd3, 1'b1, 5'd0, 1'b0);
    feed(1'b1, 8);
    check("R7 second order drops one sample", n_strobe, 32'd1);
    check("R5 second order settled value", got_val, 32'd16);
    setup(2'b11, 8'd3, 1'b1, 5'd0, 1'b0);
    feed(1'b0, 8);
    check("R7 third order drops two samples", n_strobe, 32'd0);
    feed(1'b0, 4);
    check("R5 R9 third order all zeros", got_val, 32'hFFFF_FFC0);
  endtask

  task automatic t_fast;
    logic [31:0] vals [3];
    int k;
    setup(2'b00, 8'd3, 1'b1, 5'd0, 1'b0);
    k = 0;
    for (int i = 0; i < 16; i++) begin
      send_bit(1'b1, 1'b0);
      if (got_new && k < 3) begin vals[k] = got_val; k++; end
    end
    check("R7 fast variant drops one sample", n_strobe, 32'd3);
    check("R6 fast sample 1", vals[0], 32'd80);
    check("R6 fast sample 2", vals[1], 32'd144);
    check("R6 fast sample 3", vals[2], 32'd208);
  endtask

  task automatic t_enable;
    logic [31:0] held;
    setup(2'b01, 8'd0, 1'b1, 5'd0, 1'b0);
    held = data_out;
    @(negedge clk); glob_en = 1'b0;
    feed(1'b1, 6);
    check("R3 no strobe with global enable low", n_strobe, 32'd0);
    @(negedge clk); glob_en = 1'b1; chan_en = 1'b0;
    feed(1'b0, 6);
    check("R3 no strobe with channel enable low", n_strobe, 32'd0);
    check("R3 output held while disabled", data_out, held);
  endtask

  task automatic t_sync;
    setup(2'b01, 8'd3, 1'b1, 5'd0, 1'b0);
    feed(1'b1, 2);
    @(negedge clk); sync_pulse = 1'b1;
    @(negedge clk); sync_pulse = 1'b0;
    feed(1'b0, 2);
    check("R8 pulse ignored when disabled", {31'b0, got_new}, 32'h1);
    check("R8 block kept across ignored pulse", got_val, 32'd0);

    setup(2'b01, 8'd3, 1'b1, 5'd0, 1'b1);
    feed(1'b1, 2);
    @(negedge clk); sync_pulse = 1'b1;
    @(negedge clk); sync_pulse = 1'b0;
    feed(1'b0, 3);
    check("R8 count restarted by pulse", n_strobe, 32'd0);
    feed(1'b0, 1);
    check("R8 state cleared by pulse", got_val, 32'hFFFF_FFFC);

    // pulse coincides with the bit that would close the block
    setup(2'b01, 8'd3, 1'b1, 5'd0, 1'b1);
    feed(1'b1, 3);
    send_bit(1'b1, 1'b1);
    check("R8 no strobe on coincident pulse", {31'b0, got_new}, 32'h0);
    feed(1'b0, 4);
    check("R8 one strobe after restart", n_strobe, 32'd1);
    check("R8 coincident bit dropped", got_val, 32'hFFFF_FFFC);
  endtask

  task automatic t_format16;
    setup(2'b01, 8'd3, 1'b0, 5'd0, 1'b0);
    feed(1'b0, 4);
    check("R10 window at shift 0", got_val, 32'hFFFC_0000);
    setup(2'b11, 8'd255, 1'b0, 5'd10, 1'b0);
    feed(1'b1, 767);
    check("R2 ratio 256 no early strobe", n_strobe, 32'd0);
    feed(1'b1, 1);
    check("R2 ratio 256 strobe", n_strobe, 32'd1);
    check("R10 window at shift 10", got_val, 32'h4000_0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_first_order();
        t_second_third();
        t_fast();
        t_enable();
        t_sync();
        t_format16();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule